// File: doc/BRIEF.md
# Control Endpoint Handshake Sequencer

This block is the transaction-level sequencer behind endpoint zero of a full-speed USB function. A serial interface engine upstream has already decoded the packets on the wire. It passes each one in as a single event: a SETUP, IN or OUT token, an ACK handshake, or a data packet with its toggle bit. For a data packet that follows a SETUP token, the engine also passes two decoded facts from the 8-byte request: its direction and whether its length field is zero. The sequencer chooses the reply the engine must transmit, which is ACK, NAK, DATA0 or DATA1, and says whether a DATA reply carries no payload.

The sequencer keeps four flags that it shares with firmware:
- transmit-ready, which firmware sets when the FIFO holds a packet;
- transmit-done;
- setup-received;
- out-received.

It walks the setup, data and status stages of control-read, control-write and no-data transfers. It handles retries and DATA0/DATA1 alternation on its own, and it latches the transfer direction.

Events arrive on a valid/ready stream and replies leave on another. Each accepted event produces at most one reply. While a reply waits for the engine (`rsp_valid` high, `rsp_ready` low), the reply holds stable and `evt_ready` stays low, so no further event is taken. An event counts as accepted on a clock edge where `evt_valid` and `evt_ready` are both high. Flags, the direction bit, the interrupt and the reply register all update on that same edge.

Top module: `ctl_ep_handshake`

## Requirements
- R1: After reset no reply is pending, `evt_ready` is 1, and all four flags, `dir_rd` and `irq` are 0.
- R2: `evt_kind` codes are 0 SETUP token, 1 IN token, 2 OUT token, 3 ACK handshake and 4 data packet. A SETUP token is taken in any stage and gets no reply. It restarts the transfer at the setup stage with the toggle forced to DATA0.
- R3: `rsp_code` values are 0 ACK, 1 NAK, 2 DATA0 and 3 DATA1. The data packet after a SETUP token is answered ACK. It sets setup-received and latches `dir_rd` from `evt_setup_rd`, and the toggle becomes DATA1. The next stage is the no-data status stage if `evt_setup_nolen` is 1; otherwise it is the read data stage if `dir_rd` is 1, or the write data stage if not.
- R4: In the read data stage, an IN token is answered with a non-empty DATA packet carrying the current toggle if transmit-ready is set, so successive packets alternate DATA1, DATA0, DATA1. If transmit-ready is clear, the IN token gets NAK and nothing changes.
- R5: Until the host ACKs, a repeated IN is answered with the same PID. The ACK clears transmit-ready, sets transmit-done and flips the toggle.
- R6: An OUT token in the read data stage starts the read status stage. Its data packet gets NAK while transmit-done is set. Once firmware clears transmit-done, the data packet gets ACK and the endpoint returns to idle.
- R7: In the write data stage, an OUT data packet whose toggle bit (`evt_pid1`) matches is answered ACK, sets out-received and flips the toggle. A mismatching packet is answered ACK and discarded, leaving out-received and the toggle unchanged. Any data packet that arrives while out-received is still set gets NAK.
- R8: In the write status stage (entered by IN from the write data stage) and in the no-data status stage, each IN is answered with a zero-length DATA1 (`rsp_zlp` 1), repeated until ACK. That ACK sets transmit-done and returns to idle.
- R9: An ACK that sets transmit-done makes `irq` high for exactly one cycle when `irq_en` is 1. It leaves `irq` low when `irq_en` is 0.
- R10: If a hardware update and a firmware strobe hit the same flag in one cycle, the setting side wins. A hardware set of transmit-done beats `fw_clr_tx_done`, and `fw_set_tx_ready` beats the hardware clear on ACK.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `evt_ready` is 0, the reply holds stable, and an offered event has no effect.
- R12: A token, handshake or data packet that the current stage does not expect gets no reply and changes no flag. Examples are any event other than SETUP in idle, and an ACK with no DATA outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken (no reply pending) |
| evt_kind | input | 3 | Event code (R2) |
| evt_pid1 | input | 1 | Data packet carries DATA1 |
| evt_setup_rd | input | 1 | Setup request direction is device-to-host |
| evt_setup_nolen | input | 1 | Setup request has zero length |
| rsp_valid | output | 1 | Reply pending |
| rsp_ready | input | 1 | Engine takes the reply |
| rsp_code | output | 2 | Reply code (R3) |
| rsp_zlp | output | 1 | DATA reply has no payload |
| fw_set_tx_ready | input | 1 | Firmware strobe: packet loaded |
| fw_clr_tx_done | input | 1 | Firmware strobe: clear transmit-done |
| fw_clr_rx_setup | input | 1 | Firmware strobe: clear setup-received |
| fw_clr_rx_out | input | 1 | Firmware strobe: clear out-received |
| irq_en | input | 1 | Completion interrupt enable |
| tx_ready | output | 1 | Transmit-ready flag |
| tx_done | output | 1 | Transmit-done flag |
| rx_setup | output | 1 | Setup-received flag |
| rx_out | output | 1 | Out-received flag |
| dir_rd | output | 1 | Latched transfer direction, 1 = read |
| irq | output | 1 | One-cycle completion pulse |

## Verification
An ACK from the host and a firmware strobe on the same flag can land on one clock edge. This happens with `fw_set_tx_ready` while the sequencer is clearing transmit-ready on a read-data ACK, and with `fw_clr_tx_done` while a status-stage ACK is setting transmit-done. The bench drives the firmware strobe in the very cycle the ACK event is accepted. It judges the result from the flag pins at the next sample: the setting side must survive, and the rest of the ACK's effects (the other flag, the interrupt, the next reply) must be unchanged. A held reply colliding with a newly offered event is also provoked, and is judged by the event not being taken.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  localparam int KIND_W = 3;
  localparam int RSP_W  = 2;
  localparam int NFLAG  = 4;

  localparam int F_TXRDY   = 0;
  localparam int F_TXDONE  = 1;
  localparam int F_RXSETUP = 2;
  localparam int F_RXOUT   = 3;

  typedef enum logic [KIND_W-1:0] {
    EV_SETUP = 3'd0,
    EV_IN    = 3'd1,
    EV_OUT   = 3'd2,
    EV_ACK   = 3'd3,
    EV_DATA  = 3'd4
  } ev_kind_e;

  typedef enum logic [RSP_W-1:0] {
    RP_ACK   = 2'd0,
    RP_NAK   = 2'd1,
    RP_DATA0 = 2'd2,
    RP_DATA1 = 2'd3
  } rsp_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_DATA,
    ST_WR_DATA,
    ST_ST_ND,
    ST_ST_RD,
    ST_ST_WR
  } stage_e;

endpackage

// File: rtl/ctl_ep_flags.sv
module ctl_ep_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    // R10: a set in the same cycle as a clear must leave the flag high
    a_r10_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
  end

endmodule

// File: rtl/ctl_ep_rsp.sv
module ctl_ep_rsp
  import ctl_ep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  rsp_code_e code_i,
  input  logic      zlp_i,
  input  logic      ready_i,
  output logic      valid_o,
  output rsp_code_e code_o,
  output logic      zlp_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= RP_ACK;
      zlp_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      code_o  <= code_i;
      zlp_o   <= zlp_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R11: a stalled reply keeps its content
  a_r11_hold_reply : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(code_o) && $stable(zlp_o));

  // R11: the sequencer never overwrites a pending reply
  a_r11_no_overrun : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);

endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  ev_kind_e         kind_i,
  input  logic             pid1_i,
  input  logic             setup_rd_i,
  input  logic             setup_nolen_i,
  input  logic             tx_ready_i,
  input  logic             tx_done_i,
  input  logic             rx_out_i,
  input  logic             irq_en_i,
  output logic             rsp_load_o,
  output rsp_code_e        rsp_code_o,
  output logic             rsp_zlp_o,
  output logic [NFLAG-1:0] hw_set_o,
  output logic [NFLAG-1:0] hw_clr_o,
  output logic             dir_rd_o,
  output logic             irq_o
);

  stage_e st_q, st_d;
  logic   tog_q, tog_d;
  logic   wack_q, wack_d;
  logic   opend_q, opend_d;
  logic   dir_d, irq_d;

  function automatic rsp_code_e pid_of(input logic t);
    return t ? RP_DATA1 : RP_DATA0;
  endfunction

  always_comb begin
    st_d       = st_q;
    tog_d      = tog_q;
    wack_d     = wack_q;
    opend_d    = opend_q;
    dir_d      = dir_rd_o;
    irq_d      = 1'b0;
    rsp_load_o = 1'b0;
    rsp_code_o = RP_ACK;
    rsp_zlp_o  = 1'b0;
    hw_set_o   = '0;
    hw_clr_o   = '0;
    if (fire_i) begin
      case (kind_i)
        EV_SETUP: begin
          st_d    = ST_SETUP;
          tog_d   = 1'b0;
          wack_d  = 1'b0;
          opend_d = 1'b1;
        end
        EV_IN: begin
          wack_d  = 1'b0;
          opend_d = 1'b0;
          case (st_q)
            ST_RD_DATA: begin
              rsp_load_o = 1'b1;
              if (tx_ready_i) begin
                rsp_code_o = pid_of(tog_q);
                wack_d     = 1'b1;
              end else begin
                rsp_code_o = RP_NAK;
              end
            end
            ST_WR_DATA, ST_ST_WR, ST_ST_ND: begin
              if (st_q != ST_ST_ND) st_d = ST_ST_WR;
              rsp_load_o = 1'b1;
              rsp_code_o = RP_DATA1;
              rsp_zlp_o  = 1'b1;
              wack_d     = 1'b1;
            end
            default: ;
          endcase
        end
        EV_OUT: begin
          wack_d = 1'b0;
          case (st_q)
            ST_RD_DATA: begin
              st_d    = ST_ST_RD;
              opend_d = 1'b1;
            end
            ST_WR_DATA, ST_ST_RD: opend_d = 1'b1;
            default:              opend_d = 1'b0;
          endcase
        end
        EV_ACK: begin
          if (wack_q) begin
            wack_d = 1'b0;
            case (st_q)
              ST_RD_DATA: begin
                hw_clr_o[F_TXRDY]  = 1'b1;
                hw_set_o[F_TXDONE] = 1'b1;
                tog_d              = ~tog_q;
                irq_d              = irq_en_i;
              end
              ST_ST_WR, ST_ST_ND: begin
                hw_set_o[F_TXDONE] = 1'b1;
                irq_d              = irq_en_i;
                st_d               = ST_IDLE;
              end
              default: ;
            endcase
          end
        end
        EV_DATA: begin
          if (opend_q) begin
            opend_d = 1'b0;
            case (st_q)
              ST_SETUP: begin
                rsp_load_o          = 1'b1;
                hw_set_o[F_RXSETUP] = 1'b1;
                dir_d               = setup_rd_i;
                tog_d               = 1'b1;
                if (setup_nolen_i)   st_d = ST_ST_ND;
                else if (setup_rd_i) st_d = ST_RD_DATA;
                else                 st_d = ST_WR_DATA;
              end
              ST_WR_DATA: begin
                rsp_load_o = 1'b1;
                if (rx_out_i) begin
                  rsp_code_o = RP_NAK;
                end else if (pid1_i == tog_q) begin
                  hw_set_o[F_RXOUT] = 1'b1;
                  tog_d             = ~tog_q;
                end
              end
              ST_ST_RD: begin
                rsp_load_o = 1'b1;
                if (tx_done_i) rsp_code_o = RP_NAK;
                else           st_d       = ST_IDLE;
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tog_q    <= 1'b0;
      wack_q   <= 1'b0;
      opend_q  <= 1'b0;
      dir_rd_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      st_q     <= st_d;
      tog_q    <= tog_d;
      wack_q   <= wack_d;
      opend_q  <= opend_d;
      dir_rd_o <= dir_d;
      irq_o    <= irq_d;
    end
  end

  // R2: any accepted SETUP token leaves the sequencer in the setup stage
  a_r2_setup_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && kind_i == EV_SETUP |=> st_q == ST_SETUP && !tog_q);

endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  output logic       evt_ready,
  input  logic [2:0] evt_kind,
  input  logic       evt_pid1,
  input  logic       evt_setup_rd,
  input  logic       evt_setup_nolen,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [1:0] rsp_code,
  output logic       rsp_zlp,
  input  logic       fw_set_tx_ready,
  input  logic       fw_clr_tx_done,
  input  logic       fw_clr_rx_setup,
  input  logic       fw_clr_rx_out,
  input  logic       irq_en,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       rx_setup,
  output logic       rx_out,
  output logic       dir_rd,
  output logic       irq
);

  logic             fire;
  logic             ld;
  rsp_code_e        ld_code, q_code;
  logic             ld_zlp;
  logic [NFLAG-1:0] hw_set, hw_clr, fw_set, fw_clr, flags;

  assign evt_ready = !rsp_valid;
  assign fire      = evt_valid && evt_ready;

  assign fw_set = {{(NFLAG-1){1'b0}}, fw_set_tx_ready};
  assign fw_clr = {fw_clr_rx_out, fw_clr_rx_setup, fw_clr_tx_done, 1'b0};

  ctl_ep_seq u_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fire_i       (fire),
    .kind_i       (ev_kind_e'(evt_kind)),
    .pid1_i       (evt_pid1),
    .setup_rd_i   (evt_setup_rd),
    .setup_nolen_i(evt_setup_nolen),
    .tx_ready_i   (flags[F_TXRDY]),
    .tx_done_i    (flags[F_TXDONE]),
    .rx_out_i     (flags[F_RXOUT]),
    .irq_en_i     (irq_en),
    .rsp_load_o   (ld),
    .rsp_code_o   (ld_code),
    .rsp_zlp_o    (ld_zlp),
    .hw_set_o     (hw_set),
    .hw_clr_o     (hw_clr),
    .dir_rd_o     (dir_rd),
    .irq_o        (irq)
  );

  ctl_ep_flags #(.N(NFLAG)) u_flags (
    .clk_i (clk),
    .rst_ni(rst_n),
    .set_i (hw_set | fw_set),
    .clr_i (hw_clr | fw_clr),
    .q_o   (flags)
  );

  ctl_ep_rsp u_rsp (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (ld),
    .code_i (ld_code),
    .zlp_i  (ld_zlp),
    .ready_i(rsp_ready),
    .valid_o(rsp_valid),
    .code_o (q_code),
    .zlp_o  (rsp_zlp)
  );

  assign rsp_code = q_code;
  assign tx_ready = flags[F_TXRDY];
  assign tx_done  = flags[F_TXDONE];
  assign rx_setup = flags[F_RXSETUP];
  assign rx_out   = flags[F_RXOUT];

  // R4: a payload-carrying DATA reply only when a packet was ready
  a_r4_data_needs_ready : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_zlp && (rsp_code == RP_DATA0 || rsp_code == RP_DATA1)
      |-> $past(tx_ready));

  // R9: the completion pulse coincides with transmit-done being set
  a_r9_irq_with_done : assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_done);

  // R2: a SETUP token never produces a reply
  a_r2_setup_silent : assert property (@(posedge clk) disable iff (!rst_n)
    fire && evt_kind == 3'd0 |=> !rsp_valid);

endmodule

// File: tb/sim_ctl_ep_handshake.sv
`timescale 1ns/1ps
module sim_ctl_ep_handshake;

  localparam int K_SETUP = 0, K_IN = 1, K_OUT = 2, K_ACK = 3, K_DATA = 4;
  localparam int C_ACK = 0, C_NAK = 1, C_D0 = 2, C_D1 = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic evt_valid, evt_ready, evt_pid1, evt_setup_rd, evt_setup_nolen;
  logic [2:0] evt_kind;
  logic rsp_valid, rsp_ready, rsp_zlp;
  logic [1:0] rsp_code;
  logic fw_set_tx_ready, fw_clr_tx_done, fw_clr_rx_setup, fw_clr_rx_out, irq_en;
  logic tx_ready, tx_done, rx_setup, rx_out, dir_rd, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ctl_ep_handshake u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_pid1(evt_pid1), .evt_setup_rd(evt_setup_rd), .evt_setup_nolen(evt_setup_nolen),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_zlp(rsp_zlp),
    .fw_set_tx_ready(fw_set_tx_ready), .fw_clr_tx_done(fw_clr_tx_done),
    .fw_clr_rx_setup(fw_clr_rx_setup), .fw_clr_rx_out(fw_clr_rx_out), .irq_en(irq_en),
    .tx_ready(tx_ready), .tx_done(tx_done), .rx_setup(rx_setup), .rx_out(rx_out),
    .dir_rd(dir_rd), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flag order {rx_out, rx_setup, tx_done, tx_ready}
  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk({req, " flags"}, int'({rx_out, rx_setup, tx_done, tx_ready}), int'(exp));
  endtask

  task automatic drive_fw(input logic [3:0] v);
    {fw_clr_rx_out, fw_clr_rx_setup, fw_clr_tx_done, fw_set_tx_ready} = v;
  endtask

  task automatic fw(input logic [3:0] v);
    @(negedge clk);
    drive_fw(v);
    @(posedge clk); #1;
    drive_fw(4'b0);
  endtask

  // fwv bits: [0] set tx_ready, [1] clr tx_done, [2] clr rx_setup, [3] clr rx_out
  task automatic xact(input int kind, input bit pid1, input bit srd, input bit snol,
                      input logic [3:0] fwv, input bit ev, input int ecode,
                      input bit ezlp, input string req);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = kind[2:0]; evt_pid1 = pid1;
    evt_setup_rd = srd; evt_setup_nolen = snol;
    drive_fw(fwv);
    @(posedge clk); #1;
    evt_valid = 1'b0;
    drive_fw(4'b0);
    @(negedge clk);
    chk({req, " rsp_valid"}, int'(rsp_valid), int'(ev));
    if (ev) begin
      chk({req, " rsp_code"}, int'(rsp_code), ecode);
      chk({req, " rsp_zlp"}, int'(rsp_zlp), int'(ezlp));
    end
    if (rsp_valid) begin
      rsp_ready = 1'b1;
      @(posedge clk); #1;
      rsp_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic tog;
    logic [4:0] pat;
    rst_n = 1'b0; evt_valid = 1'b0; evt_kind = 3'd0; evt_pid1 = 1'b0;
    evt_setup_rd = 1'b0; evt_setup_nolen = 1'b0; rsp_ready = 1'b0; irq_en = 1'b0;
    drive_fw(4'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 evt_ready", int'(evt_ready), 1);
    chk("R1 dir_rd", int'(dir_rd), 0);
    chk("R1 irq", int'(irq), 0);
    chk_flags("R1", 4'b0000);

    // R12 every non-SETUP event in idle is silent
    for (int k = K_IN; k <= K_DATA; k++) begin
      xact(k, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 0, 1'b0, "R12 idle event");
      chk_flags("R12 idle", 4'b0000);
    end

    // control read with three packets, interrupt enabled
    irq_en = 1'b1;
    xact(K_SETUP, 0, 0, 0, 4'b0, 0, 0, 0, "R2 setup token");
    xact(K_DATA, 0, 1, 0, 4'b0, 1, C_ACK, 0, "R3 setup data read");
    chk_flags("R3 read", 4'b0100);
    chk("R3 dir_rd", int'(dir_rd), 1);
    fw(4'b0100);
    xact(K_ACK, 0, 0, 0, 4'b0, 0, 0, 0, "R12 ack with nothing outstanding");
    xact(K_IN, 0, 0, 0, 4'b0, 1, C_NAK, 0, "R4 in without packet");
    chk_flags("R4 nak", 4'b0000);
    tog = 1'b1;
    for (int k = 0; k < 3; k++) begin
      fw(4'b0001);
      xact(K_IN, 0, 0, 0, 4'b0, 1, tog ? C_D1 : C_D0, 0, "R4 read packet");
      if (k == 1) xact(K_IN, 0, 0, 0, 4'b0, 1, tog ? C_D1 : C_D0, 0, "R5 retry same pid");
      if (k == 2) begin
        xact(K_ACK, 0, 0, 0, 4'b0001, 0, 0, 0, "R10 ack with fw set");
        chk_flags("R10 fw set wins over hw clear", 4'b0011);
      end else begin
        xact(K_ACK, 0, 0, 0, 4'b0, 0, 0, 0, "R5 ack");
        chk_flags("R5 after ack", 4'b0010);
      end
      chk("R9 irq pulse", int'(irq), 1);
      @(negedge clk);
      chk("R9 irq one cycle", int'(irq), 0);
      tog = ~tog;
    end
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R6 status out token");
    xact(K_DATA, 1, 0, 0, 4'b0, 1, C_NAK, 0, "R6 nak while done");
    fw(4'b0010);
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R6 retried out token");
    xact(K_DATA, 1, 0, 0, 4'b0, 1, C_ACK, 0, "R6 ack after clear");
    xact(K_IN, 0, 0, 0, 4'b0, 0, 0, 0, "R6 idle after status");

    // control write, interrupt disabled, toggle sweep
    irq_en = 1'b0;
    xact(K_SETUP, 0, 0, 0, 4'b0, 0, 0, 0, "R2 setup token write");
    xact(K_DATA, 0, 0, 0, 4'b0, 1, C_ACK, 0, "R3 setup data write");
    chk("R3 dir_rd write", int'(dir_rd), 0);
    fw(4'b0100);
    tog = 1'b1;
    pat = 5'b10011;
    for (int j = 0; j < 5; j++) begin
      xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R7 out token");
      xact(K_DATA, pat[j], 0, 0, 4'b0, 1, C_ACK, 0, "R7 out data");
      chk("R7 rx_out by toggle match", int'(rx_out), int'(pat[j] == tog));
      if (pat[j] == tog) begin
        tog = ~tog;
        fw(4'b1000);
      end
    end
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R7 out token");
    xact(K_DATA, tog, 0, 0, 4'b0, 1, C_ACK, 0, "R7 matching data");
    tog = ~tog;
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R7 out token");
    xact(K_DATA, tog, 0, 0, 4'b0, 1, C_NAK, 0, "R7 nak while rx_out set");
    fw(4'b1000);
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R7 out token");
    xact(K_DATA, ~tog, 0, 0, 4'b0, 1, C_ACK, 0, "R7 mismatch after nak");
    chk("R7 mismatch discarded", int'(rx_out), 0);
    xact(K_IN, 0, 0, 0, 4'b0, 1, C_D1, 1, "R8 write status zlp");
    xact(K_IN, 0, 0, 0, 4'b0, 1, C_D1, 1, "R8 write status retry");
    xact(K_ACK, 0, 0, 0, 4'b0010, 0, 0, 0, "R10 ack with fw clear");
    chk("R10 hw set beats fw clear", int'(tx_done), 1);
    chk("R9 irq disabled", int'(irq), 0);
    xact(K_IN, 0, 0, 0, 4'b0, 0, 0, 0, "R8 idle after write status");
    fw(4'b0010);

    // SETUP in the middle of a write data stage restarts it
    xact(K_SETUP, 0, 0, 0, 4'b0, 0, 0, 0, "R2 setup token");
    xact(K_DATA, 0, 0, 0, 4'b0, 1, C_ACK, 0, "R3 setup data");
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R7 out token");
    xact(K_DATA, 1, 0, 0, 4'b0, 1, C_ACK, 0, "R7 first data");
    fw(4'b1000);
    xact(K_SETUP, 0, 0, 0, 4'b0, 0, 0, 0, "R2 setup mid stage");
    xact(K_DATA, 0, 0, 0, 4'b0, 1, C_ACK, 0, "R2 restart setup data");
    xact(K_OUT, 0, 0, 0, 4'b0, 0, 0, 0, "R2 out token");
    xact(K_DATA, 1, 0, 0, 4'b0, 1, C_ACK, 0, "R2 restart expects DATA1");
    chk("R2 restarted toggle accepted", int'(rx_out), 1);
    fw(4'b1100);

    // no-data transfer with a stalled reply
    irq_en = 1'b1;
    xact(K_SETUP, 0, 0, 0, 4'b0, 0, 0, 0, "R2 setup token nodata");
    xact(K_DATA, 0, 0, 1, 4'b0, 1, C_ACK, 0, "R3 setup data nodata");
    fw(4'b0100);
    xact(K_DATA, 1, 0, 0, 4'b0, 0, 0, 0, "R12 data in nodata status");
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = 3'(K_IN);
    @(posedge clk); #1;
    evt_valid = 1'b0;
    @(negedge clk);
    chk("R8 nodata zlp valid", int'(rsp_valid), 1);
    chk("R8 nodata zlp code", int'(rsp_code), C_D1);
    chk("R11 evt_ready low", int'(evt_ready), 0);
    evt_valid = 1'b1; evt_kind = 3'(K_ACK);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 held valid", int'(rsp_valid), 1);
    chk("R11 held code", int'(rsp_code), C_D1);
    chk("R11 held zlp", int'(rsp_zlp), 1);
    chk("R11 offered ack not taken", int'(tx_done), 0);
    evt_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    chk("R11 ack still not taken", int'(tx_done), 0);
    xact(K_ACK, 0, 0, 0, 4'b0, 0, 0, 0, "R8 nodata ack");
    chk("R8 nodata done", int'(tx_done), 1);
    chk("R9 irq nodata", int'(irq), 1);
    xact(K_IN, 0, 0, 0, 4'b0, 0, 0, 0, "R12 idle after nodata");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule